// File: doc/BRIEF.md
# Streaming CRC-8/CRC-16 Checker for a Serial Port

This block keeps a running CRC beside the byte path of a serial port. Each byte strobe folds eight data bits, most significant bit first, into the running value in one clock. A select input chooses between an 8-bit CRC and a 16-bit CCITT-style CRC. One instance serves the transmit side and one serves the receive side. Software sees the running value through a read/write strobe pair. Every access returns the value and re-seeds the unit, so each frame starts from a clean seed without an extra command.

While the serial engine is stopped, software can feed bytes directly through a general-purpose port and use the unit as a plain CRC engine. On the transmit side, an insertion request snapshots the CRC and emits it as one or two bytes on an output stream, to be appended to the outgoing data. For a 16-bit CRC the byte order can be chosen. When the last byte has gone out, a sticky flag is set, and the next value read clears it.

Top module: `crc_stream_unit`

## Requirements
- R1: After reset, `reg_rdata` reads 0xFFFF, and `ins_vld` and `ins_flag` are 0.
- R2: With `poly_sel`=1, every accepted byte updates the value in the same clock using the polynomial 0x1021. The byte is taken MSB first, and there is no reflection and no final XOR. From seed 0xFFFF, the ASCII bytes "123456789" give 0x29B1.
- R3: With `poly_sel`=0, bits 7:0 hold an 8-bit CRC with polynomial 0x07, seed 0xFF, MSB first, no reflection and no final XOR. Bits 15:8 are don't-care.
- R4: A cycle with `reg_rd`=1 shows the current value on `reg_rdata`. At that clock edge the value reloads the seed (0xFFFF if `poly_sel`=1, low byte 0xFF if 0). The reload takes precedence over a byte accepted in the same cycle.
- R5: A `reg_wr` pulse reloads the seed in the same way as R4, also over a simultaneous byte.
- R6: Source selection works as follows:
  - With `eng_en`=1, only `byte_vld`/`byte_data` feed the CRC, and `gp_wr` has no effect.
  - With `eng_en`=0 and `gp_en`=1, only `gp_wr`/`gp_data` feed it.
  - With both `eng_en`=0 and `gp_en`=0, neither strobe changes the value.
- R7: An `ins_req` with `ins_en`=1 snapshots the value and takes `poly_sel` and `byte_swap` at that edge. `ins_vld` is then high from the next cycle:
  - For the 8-bit CRC: one cycle carrying bits 7:0.
  - For the 16-bit CRC with `byte_swap`=0: two consecutive cycles carrying bits 15:8, then 7:0.
  - For the 16-bit CRC with `byte_swap`=1: two consecutive cycles carrying bits 7:0, then 15:8.
- R8: `ins_req` is ignored while `ins_en`=0 or while an insertion is still emitting bytes.
- R9: `ins_flag` is set at the edge that ends the last inserted byte. A `reg_rd` clears it. If the set and the clear happen in the same cycle, the flag ends set.
- R10: Emitting inserted bytes does not change the running CRC value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poly_sel | input | 1 | 0: 8-bit CRC, 1: 16-bit CRC |
| eng_en | input | 1 | Serial engine running |
| gp_en | input | 1 | General-purpose software feed enable |
| byte_vld | input | 1 | Byte strobe from the shift path |
| byte_data | input | 8 | Byte from the shift path |
| gp_wr | input | 1 | Byte strobe from software |
| gp_data | input | 8 | Byte from software |
| reg_rd | input | 1 | Value register read strobe |
| reg_wr | input | 1 | Value register write strobe |
| ins_en | input | 1 | Automatic insertion enable |
| byte_swap | input | 1 | CRC-16 insertion order, 1 = low byte first |
| ins_req | input | 1 | Request to insert the CRC |
| reg_rdata | output | 16 | Running CRC value |
| ins_vld | output | 1 | Inserted byte valid |
| ins_byte | output | 8 | Inserted byte |
| ins_flag | output | 1 | Insertion done, cleared on read |

## Verification
The bench builds the block with its default polynomials, 0x07 and 0x1021. It can therefore check the 16-bit result against the well-known 0x29B1 check value, in addition to a bit-serial model. Both widths are exercised within one run by toggling `poly_sel`. This brings within reach the width switch at reseed, the single-byte versus two-byte insertion lengths, and both CRC-16 byte orders.

// File: rtl/crc_stream_unit.sv
module crc_stream_unit #(
  parameter logic [7:0]  POLY8  = 8'h07,
  parameter logic [15:0] POLY16 = 16'h1021
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        poly_sel,
  input  logic        eng_en,
  input  logic        gp_en,
  input  logic        byte_vld,
  input  logic [7:0]  byte_data,
  input  logic        gp_wr,
  input  logic [7:0]  gp_data,
  input  logic        reg_rd,
  input  logic        reg_wr,
  input  logic        ins_en,
  input  logic        byte_swap,
  input  logic        ins_req,
  output logic [15:0] reg_rdata,
  output logic        ins_vld,
  output logic [7:0]  ins_byte,
  output logic        ins_flag
);

  localparam logic [15:0] SEED_WIDE   = 16'hFFFF;
  localparam logic [15:0] SEED_NARROW = 16'h00FF;

  function automatic logic [15:0] step_byte(input logic [15:0] c, input logic [7:0] d,
                                            input logic wide);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (wide) begin
        fb = r[15] ^ d[i];
        r  = {r[14:0], 1'b0} ^ (fb ? POLY16 : 16'h0000);
      end else begin
        fb = r[7] ^ d[i];
        r  = {8'h00, r[6:0], 1'b0} ^ {8'h00, (fb ? POLY8 : 8'h00)};
      end
    end
    return r;
  endfunction

  logic [15:0] crc_q, snap_q;
  logic [1:0]  left_q;
  logic        wide_q, swap_q;

  wire        access = reg_rd | reg_wr;
  wire        feed   = eng_en ? byte_vld : (gp_en & gp_wr);
  wire [7:0]  din    = eng_en ? byte_data : gp_data;
  wire        start  = ins_en & ins_req & (left_q == 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n)      crc_q <= SEED_WIDE;
    else if (access) crc_q <= poly_sel ? SEED_WIDE : SEED_NARROW;
    else if (feed)   crc_q <= step_byte(crc_q, din, poly_sel);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q <= 16'h0000;
      left_q <= 2'd0;
      wide_q <= 1'b0;
      swap_q <= 1'b0;
    end else if (start) begin
      snap_q <= crc_q;
      left_q <= poly_sel ? 2'd2 : 2'd1;
      wide_q <= poly_sel;
      swap_q <= byte_swap;
    end else if (left_q != 2'd0) begin
      left_q <= left_q - 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              ins_flag <= 1'b0;
    else if (left_q == 2'd1) ins_flag <= 1'b1;
    else if (reg_rd)         ins_flag <= 1'b0;
  end

  wire hi_first = ~swap_q;
  wire take_hi  = (left_q == 2'd2) ? hi_first : ~hi_first;

  assign reg_rdata = crc_q;
  assign ins_vld   = (left_q != 2'd0);
  assign ins_byte  = (wide_q && take_hi) ? snap_q[15:8] : snap_q[7:0];

  // R4 R5
  seed_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd || reg_wr) |=> (reg_rdata == ($past(poly_sel) ? SEED_WIDE : SEED_NARROW)));

  // R6
  gp_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_en && !byte_vld && !reg_rd && !reg_wr) |=> $stable(reg_rdata));

  // R8
  no_spurious_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_vld && !(ins_en && ins_req)) |=> !ins_vld);

  // R9
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ins_flag) |-> ($past(ins_vld) && !ins_vld));

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !ins_vld) |=> !ins_flag);

  // R10
  ins_keeps_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_vld && !reg_rd && !reg_wr && !byte_vld && !gp_wr) |=> $stable(reg_rdata));

endmodule

// File: tb/test_crc_stream_unit.sv
module test_crc_stream_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic poly_sel = 1'b1, eng_en = 1'b0, gp_en = 1'b0, byte_vld = 1'b0, gp_wr = 1'b0;
  logic [7:0] byte_data = 8'h00, gp_data = 8'h00;
  logic reg_rd = 1'b0, reg_wr = 1'b0, ins_en = 1'b0, byte_swap = 1'b0, ins_req = 1'b0;
  logic [15:0] reg_rdata;
  logic ins_vld, ins_flag;
  logic [7:0] ins_byte;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [15:0] m;
  logic [7:0] expq[$];

  always #5 clk = ~clk;

  crc_stream_unit i_crc_stream_unit (
    .clk(clk), .rst_n(rst_n), .poly_sel(poly_sel), .eng_en(eng_en), .gp_en(gp_en),
    .byte_vld(byte_vld), .byte_data(byte_data), .gp_wr(gp_wr), .gp_data(gp_data),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .ins_en(ins_en), .byte_swap(byte_swap),
    .ins_req(ins_req), .reg_rdata(reg_rdata), .ins_vld(ins_vld), .ins_byte(ins_byte),
    .ins_flag(ins_flag));

  function automatic logic [15:0] ref_step(input logic [15:0] c, input logic [7:0] d,
                                           input logic wide);
    logic [16:0] s;
    logic [8:0]  n;
    if (wide) begin
      s = {1'b0, c};
      for (int k = 0; k < 8; k++) begin
        s = {s[15:0], 1'b0};
        if (s[16] ^ d[7-k]) s[15:0] = s[15:0] ^ 16'h1021;
      end
      return s[15:0];
    end
    n = {1'b0, c[7:0]};
    for (int k = 0; k < 8; k++) begin
      n = {n[7:0], 1'b0};
      if (n[8] ^ d[7-k]) n[7:0] = n[7:0] ^ 8'h07;
    end
    return {8'h00, n[7:0]};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_val(input string tag);
    if (poly_sel) chk(tag, reg_rdata, m);
    else chk(tag, {8'h00, reg_rdata[7:0]}, {8'h00, m[7:0]});
  endtask

  task automatic feed_eng(input logic [7:0] b);
    byte_vld = 1'b1; byte_data = b;
    @(negedge clk);
    byte_vld = 1'b0;
    m = ref_step(m, b, poly_sel);
  endtask

  task automatic feed_gp(input logic [7:0] b);
    gp_wr = 1'b1; gp_data = b;
    @(negedge clk);
    gp_wr = 1'b0;
    m = ref_step(m, b, poly_sel);
  endtask

  task automatic do_wr;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    m = poly_sel ? 16'hFFFF : 16'h00FF;
  endtask

  task automatic do_rd;
    reg_rd = 1'b1;
    chk_val("R4 read value");
    @(negedge clk);
    reg_rd = 1'b0;
    m = poly_sel ? 16'hFFFF : 16'h00FF;
    chk_val("R4 reseed after read");
  endtask

  task automatic insert(input logic swap);
    if (!poly_sel) expq.push_back(m[7:0]);
    else if (!swap) begin expq.push_back(m[15:8]); expq.push_back(m[7:0]); end
    else begin expq.push_back(m[7:0]); expq.push_back(m[15:8]); end
    byte_swap = swap; ins_req = 1'b1;
    @(negedge clk);
    ins_req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && ins_vld) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected inserted byte actual=%h expected=none", ins_byte);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        if (ins_byte !== e) begin
          errors++;
          $display("FAIL R7 inserted byte actual=%h expected=%h", ins_byte, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    string msg;
    logic [15:0] held;
    msg = "123456789";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset value", reg_rdata, 16'hFFFF);
    chk("R1 reset ins_vld", {15'd0, ins_vld}, 16'd0);
    chk("R1 reset flag", {15'd0, ins_flag}, 16'd0);
    m = 16'hFFFF;

    // R2 check string
    eng_en = 1'b1; poly_sel = 1'b1;
    for (int i = 0; i < 9; i++) feed_eng(msg[i]);
    chk("R2 check value", reg_rdata, 16'h29B1);
    chk_val("R2 model");
    do_rd();
    feed_eng(8'h00); feed_eng(8'hFF); feed_eng(8'h5A);
    chk_val("R2 mixed bytes");

    // R3 narrow CRC
    poly_sel = 1'b0;
    do_wr();
    chk_val("R5 write reseed narrow");
    for (int i = 0; i < 9; i++) feed_eng(msg[i]);
    chk_val("R3 check string narrow");
    feed_eng(8'h80); feed_eng(8'h01);
    chk_val("R3 more bytes");

    // R4/R5 precedence over a byte
    reg_wr = 1'b1; byte_vld = 1'b1; byte_data = 8'h33;
    @(negedge clk);
    reg_wr = 1'b0; byte_vld = 1'b0; m = 16'h00FF;
    chk_val("R5 write beats byte");
    feed_eng(8'h77);
    reg_rd = 1'b1; byte_vld = 1'b1; byte_data = 8'h44;
    chk_val("R4 read value with byte");
    @(negedge clk);
    reg_rd = 1'b0; byte_vld = 1'b0; m = 16'h00FF;
    chk_val("R4 read beats byte");

    // R6 general-purpose path
    poly_sel = 1'b1; eng_en = 1'b0; gp_en = 1'b1;
    do_wr();
    feed_gp(8'hA5); feed_gp(8'h3C); feed_gp(8'h00); feed_gp(8'hFF);
    chk_val("R6 gp feed");
    byte_vld = 1'b1; byte_data = 8'h12; @(negedge clk); byte_vld = 1'b0;
    chk_val("R6 shift byte ignored when engine off");
    eng_en = 1'b1;
    gp_wr = 1'b1; gp_data = 8'h99; @(negedge clk); gp_wr = 1'b0;
    chk_val("R6 gp ignored when engine on");
    eng_en = 1'b0; gp_en = 1'b0;
    gp_wr = 1'b1; byte_vld = 1'b1; @(negedge clk); gp_wr = 1'b0; byte_vld = 1'b0;
    chk_val("R6 nothing fed when both off");

    // R7 insertion
    eng_en = 1'b1; ins_en = 1'b1; poly_sel = 1'b1;
    feed_eng(8'hC3); feed_eng(8'h1E);
    held = m;
    insert(1'b0);
    chk("R9 flag set", {15'd0, ins_flag}, 16'd1);
    chk("R10 crc unchanged by insertion", reg_rdata, held);
    do_rd();
    chk("R9 flag cleared by read", {15'd0, ins_flag}, 16'd0);
    feed_eng(8'h6B);
    insert(1'b1);
    do_rd();
    poly_sel = 1'b0;
    do_wr();
    feed_eng(8'hE7);
    insert(1'b0);
    chk("R9 flag after narrow", {15'd0, ins_flag}, 16'd1);
    do_rd();

    // R8 ignored requests
    ins_en = 1'b0; ins_req = 1'b1; @(negedge clk); ins_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 no flag when disabled", {15'd0, ins_flag}, 16'd0);
    ins_en = 1'b1; poly_sel = 1'b1;
    do_wr();
    feed_eng(8'h2F);
    expq.push_back(m[15:8]); expq.push_back(m[7:0]);
    byte_swap = 1'b0; ins_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    ins_req = 1'b0;
    reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0; m = 16'hFFFF;
    chk("R9 set wins over clear", {15'd0, ins_flag}, 16'd1);
    repeat (3) @(negedge clk);
    chk("R8 busy request dropped", expq.size(), 16'd0);
    chk_val("R4 reseed during insertion");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule